// File: doc/BRIEF.md
# Descriptor Chain DMA Engine

The block is the front end of a DMA channel. It hands a data path a series of contiguous transfer segments, each an address, a length and a flag. Each segment waits on a valid/ready handshake. Software programs a list base, a link word, a buffer base and a buffer size through a small write port, then starts the engine through a control register. In single mode the engine issues the programmed buffer once. In chain mode it walks a list of three-word descriptors in memory: a link word, a buffer base and a buffer size. It fetches each descriptor through a request/grant read port.

A descriptor's link word carries three things: the byte offset of the next descriptor from the list base, a flag marking that a next descriptor exists, and a flag that makes the next fetch reload the size word. A third flag travels with the segment to the data path. Every segment is checked for alignment before it is offered. A violation stops the chain with an error flag raised.

Top module: `chain_dma_engine`

## Requirements
- R1: After reset, seg_valid, mrd_req, done and err are all low.
- R2: Writing the control register (cfg_addr 0) with bit 0 set and bit 1 clear issues exactly one segment, with the programmed buffer base (cfg_addr 3) and size (cfg_addr 4). No memory read is made, whatever the link word says.
- R3: Writing control with bits 0 and 1 both set runs chain mode. After a segment is accepted whose link word has bit 31 set, the engine reads list base (cfg_addr 1) plus the link offset (link bits 15:0). The word at +0 becomes the new link word, +4 the new buffer base and +8 the new size. It then issues the next segment.
- R4: A segment whose link bit 31 is clear, or any segment in single mode, is the final one. done is high for exactly the one cycle after its handshake and low at all other times.
- R5: When the accepted segment's link bit 30 is clear, the next descriptor's size word is not read. The next segment reuses the previous length, so that step costs two memory reads instead of three.
- R6: seg_flag carries bit 29 of the link word of the descriptor being issued.
- R7: A buffer base with either of bits 1:0 set raises err instead of offering that segment. The engine then stops without done.
- R8: In chain mode, a size not a multiple of 2^ALIGN_LOG2 (32 by default) on a descriptor whose link bit 31 is set raises err, as in R7. The final descriptor's size is unconstrained.
- R9: Writing zero to the control register stops the engine. From the next cycle seg_valid and mrd_req are low and no done follows.
- R10: While seg_valid is high and seg_ready low, seg_addr, seg_len and seg_flag hold still.
- R11: While mrd_req is high and mrd_gnt low, mrd_req stays high and mrd_addr holds still.
- R12: A control write with bit 0 clear and bit 1 set starts nothing. No segment, read or done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 control, 1 list base, 2 link word, 3 buffer base, 4 buffer size |
| cfg_wdata | input | 32 | Register write data |
| mrd_req | output | 1 | Descriptor read request |
| mrd_addr | output | 32 | Descriptor word byte address |
| mrd_gnt | input | 1 | Read request accepted |
| mrd_rvalid | input | 1 | Read data valid (in order, at least one cycle after grant) |
| mrd_rdata | input | 32 | Read data |
| seg_valid | output | 1 | Segment offered |
| seg_ready | input | 1 | Segment accepted by the data path |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 32 | Segment length in bytes |
| seg_flag | output | 1 | Buffer-ready acknowledge flag of the segment |
| done | output | 1 | One-cycle pulse after the final segment is accepted |
| err | output | 1 | Alignment error, held until the next start |

## Verification
A wrong descriptor-field update shows up at the segment port in the very next segment. The length, base or flag differs from the walk the bench computes over its memory image. An offset or flag decoded from the wrong bits sends a read to an address the bench did not expect. A miscounted fetch shows as an extra or missing grant, seen in the total number of reads. A wrong end-of-chain or error decision shows within one cycle of the last handshake: done appears, fails to appear, or arrives alongside an err it should not have.

// File: rtl/chain_dma_pkg.sv
// Shared constants and state type of the descriptor chain DMA engine.
// Assumes 32-bit data words and link-word flags in the top three bits.
package chain_dma_pkg;
    localparam int DATA_W       = 32;
    localparam int LNK_NEXT_BIT = 31;
    localparam int LNK_UPD_BIT  = 30;
    localparam int LNK_ACK_BIT  = 29;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_LIST  = 3'd1;
    localparam logic [2:0] REG_LINK  = 3'd2;
    localparam logic [2:0] REG_BASE  = 3'd3;
    localparam logic [2:0] REG_SIZE  = 3'd4;

    localparam logic [1:0] WORD_LINK = 2'd0;
    localparam logic [1:0] WORD_BASE = 2'd1;
    localparam logic [1:0] WORD_SIZE = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_FETCH
    } eng_state_e;
endpackage

// File: rtl/chain_dma_regs.sv
// Holds the list base and the current descriptor (link fields, buffer base,
// buffer size). Software writes land only when the top allows them (idle);
// descriptor words fetched from memory overwrite the matching field.
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int DW    = 32,
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [2:0]       cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic             ld_valid,
    input  logic [1:0]       ld_idx,
    input  logic [DW-1:0]    ld_data,
    output logic [DW-1:0]    list_base,
    output logic [DW-1:0]    buf_base,
    output logic [DW-1:0]    buf_size,
    output logic [OFS_W-1:0] lnk_ofs,
    output logic             lnk_next,
    output logic             lnk_upd,
    output logic             lnk_ack
);
    // Register update: memory loads take precedence over (idle-only) writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            list_base <= '0;
            buf_base  <= '0;
            buf_size  <= '0;
            lnk_ofs   <= '0;
            lnk_next  <= 1'b0;
            lnk_upd   <= 1'b0;
            lnk_ack   <= 1'b0;
        end else if (ld_valid) begin
            case (ld_idx)
                WORD_LINK: begin
                    lnk_ofs  <= ld_data[OFS_W-1:0];
                    lnk_next <= ld_data[LNK_NEXT_BIT];
                    lnk_upd  <= ld_data[LNK_UPD_BIT];
                    lnk_ack  <= ld_data[LNK_ACK_BIT];
                end
                WORD_BASE: buf_base <= ld_data;
                default:   buf_size <= ld_data;
            endcase
        end else if (cfg_en) begin
            case (cfg_sel)
                REG_LIST: list_base <= cfg_wdata;
                REG_LINK: begin
                    lnk_ofs  <= cfg_wdata[OFS_W-1:0];
                    lnk_next <= cfg_wdata[LNK_NEXT_BIT];
                    lnk_upd  <= cfg_wdata[LNK_UPD_BIT];
                    lnk_ack  <= cfg_wdata[LNK_ACK_BIT];
                end
                REG_BASE: buf_base <= cfg_wdata;
                REG_SIZE: buf_size <= cfg_wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/chain_dma_fetch.sv
// Reads two or three consecutive descriptor words starting at start_addr.
// Requests are pipelined; responses arrive in order at least one cycle
// after their grant. Each response is presented with its word index.
module chain_dma_fetch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] start_addr,
    input  logic          three_words,
    output logic          mrd_req,
    output logic [DW-1:0] mrd_addr,
    input  logic          mrd_gnt,
    input  logic          mrd_rvalid,
    input  logic [DW-1:0] mrd_rdata,
    output logic          wr_valid,
    output logic [1:0]    wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          fetch_done
);
    logic          active;
    logic [DW-1:0] base_q;
    logic [1:0]    total;
    logic [1:0]    issued;
    logic [1:0]    got;

    // Request and response steering.
    always_comb begin
        mrd_req    = active && (issued != total);
        mrd_addr   = base_q + DW'({issued, 2'b00});
        wr_valid   = active && mrd_rvalid;
        wr_idx     = got;
        wr_data    = mrd_rdata;
        fetch_done = wr_valid && (got == total - 2'd1);
    end

    // Issue and receive counters.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active <= 1'b0;
            base_q <= '0;
            total  <= '0;
            issued <= '0;
            got    <= '0;
        end else if (start) begin
            active <= 1'b1;
            base_q <= start_addr;
            total  <= three_words ? 2'd3 : 2'd2;
            issued <= '0;
            got    <= '0;
        end else if (active) begin
            if (mrd_req && mrd_gnt) issued <= issued + 2'd1;
            if (wr_valid)           got    <= got + 2'd1;
            if (fetch_done)         active <= 1'b0;
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mrd_req && !mrd_gnt && !abort) |=> (mrd_req && $stable(mrd_addr)));

    // R3
    resp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (got < issued));
endmodule

// File: rtl/chain_dma_check.sv
// Alignment screen on the descriptor about to be issued: base must be word
// aligned; in chain mode a non-final size must be a block-size multiple.
module chain_dma_check #(
    parameter int DW         = 32,
    parameter int ALIGN_LOG2 = 5
) (
    input  logic [DW-1:0] buf_base,
    input  logic [DW-1:0] buf_size,
    input  logic          chain_mode,
    input  logic          lnk_next,
    output logic          bad
);
    logic size_bad;

    generate
        if (ALIGN_LOG2 > 0) begin : g_size_rule
            // Non-final chained sizes must clear the low block bits.
            always_comb size_bad = chain_mode && lnk_next && (|buf_size[ALIGN_LOG2-1:0]);
        end else begin : g_no_size_rule
            // Block size of one byte: every size is acceptable.
            always_comb size_bad = 1'b0;
        end
    endgenerate

    // Combined verdict.
    always_comb bad = (|buf_base[1:0]) || size_bad;
endmodule

// File: rtl/chain_dma_engine.sv
// Descriptor chain DMA engine top. Sequences check -> issue -> fetch per
// descriptor, in single or chain mode, and stops on error or a zero
// control write. Assumes configuration registers are written while idle.
module chain_dma_engine
    import chain_dma_pkg::*;
#(
    parameter int DW         = 32,
    parameter int OFS_W      = 16,
    parameter int ALIGN_LOG2 = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic          mrd_req,
    output logic [DW-1:0] mrd_addr,
    input  logic          mrd_gnt,
    input  logic          mrd_rvalid,
    input  logic [DW-1:0] mrd_rdata,
    output logic          seg_valid,
    input  logic          seg_ready,
    output logic [DW-1:0] seg_addr,
    output logic [DW-1:0] seg_len,
    output logic          seg_flag,
    output logic          done,
    output logic          err
);
    eng_state_e       state;
    logic             chain_mode;
    logic             ctrl_wr, start, stop, cfg_en;
    logic [DW-1:0]    list_base, buf_base, buf_size;
    logic [OFS_W-1:0] lnk_ofs;
    logic             lnk_next, lnk_upd, lnk_ack;
    logic             ld_valid, fetch_done, bad;
    logic [1:0]       ld_idx;
    logic [DW-1:0]    ld_data;
    logic             fetch_go;

    // Control decode and handshake qualifiers.
    always_comb begin
        ctrl_wr  = cfg_we && (cfg_addr == REG_CTRL);
        start    = ctrl_wr && (state == ST_IDLE) && cfg_wdata[0];
        stop     = ctrl_wr && (cfg_wdata == '0);
        cfg_en   = cfg_we && (state == ST_IDLE) && (cfg_addr != REG_CTRL);
        fetch_go = (state == ST_ISSUE) && seg_ready && chain_mode && lnk_next && !stop;
    end

    chain_dma_regs #(.DW(DW), .OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_sel(cfg_addr), .cfg_wdata(cfg_wdata),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
        .list_base(list_base), .buf_base(buf_base), .buf_size(buf_size),
        .lnk_ofs(lnk_ofs), .lnk_next(lnk_next), .lnk_upd(lnk_upd), .lnk_ack(lnk_ack)
    );

    chain_dma_fetch #(.DW(DW)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .start(fetch_go), .abort(stop),
        .start_addr(list_base + DW'(lnk_ofs)), .three_words(lnk_upd),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .wr_valid(ld_valid), .wr_idx(ld_idx), .wr_data(ld_data),
        .fetch_done(fetch_done)
    );

    chain_dma_check #(.DW(DW), .ALIGN_LOG2(ALIGN_LOG2)) u_check (
        .buf_base(buf_base), .buf_size(buf_size),
        .chain_mode(chain_mode), .lnk_next(lnk_next), .bad(bad)
    );

    // Segment port view of the current descriptor.
    always_comb begin
        seg_valid = (state == ST_ISSUE);
        seg_addr  = buf_base;
        seg_len   = buf_size;
        seg_flag  = lnk_ack;
    end

    // Engine sequencer with done pulse and sticky error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            chain_mode <= 1'b0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (stop) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (start) begin
                        state      <= ST_CHECK;
                        chain_mode <= cfg_wdata[1];
                        err        <= 1'b0;
                    end
                    ST_CHECK: begin
                        if (bad) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_ISSUE;
                        end
                    end
                    ST_ISSUE: if (seg_ready) begin
                        if (chain_mode && lnk_next) begin
                            state <= ST_FETCH;
                        end else begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                    default: if (fetch_done) state <= ST_CHECK;
                endcase
            end
        end
    end

    // R10
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && !seg_ready && !cfg_we) |=>
            (seg_valid && $stable(seg_addr) && $stable(seg_len) && $stable(seg_flag)));

    // R7
    seg_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seg_valid |-> (seg_addr[1:0] == 2'b00));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!seg_valid && !done));

    // R9
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == REG_CTRL && cfg_wdata == '0) |=> (!seg_valid && !mrd_req && !done));

    // R2
    single_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain_mode && state != ST_IDLE) |-> !mrd_req);
endmodule

// File: tb/chain_dma_engine_bench.sv
module chain_dma_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        mrd_req;
    logic [31:0] mrd_addr;
    logic        mrd_gnt = 1'b0;
    logic        mrd_rvalid = 1'b0;
    logic [31:0] mrd_rdata = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr, seg_len;
    logic        seg_flag;
    logic        done, err;

    always #5 clk = ~clk;

    chain_dma_engine u_chain_dma_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .seg_flag(seg_flag), .done(done), .err(err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int rd_count = 0;
    int rdy_mode = 0;
    int gnt_mode = 0;
    bit hold_ready = 1'b0;
    bit exp_done = 1'b0;
    bit exp_err = 1'b0;
    bit pend_done = 1'b0;
    bit stall_q = 1'b0;
    logic [64:0] stall_seg;
    logic [31:0] mem [0:255];
    logic [64:0] exp_q [$];
    int          pend_due [$];
    logic [31:0] pend_addr [$];
    logic [31:0] r_list, r_link, r_base, r_size;

    localparam logic [31:0] NXT = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;
    localparam logic [31:0] ACK = 32'h2000_0000;
    localparam logic [31:0] LIST = 32'h100;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Memory model, handshake drivers and per-cycle comparison.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
            mrd_rvalid = 1'b1;
            mrd_rdata  = mem[pend_addr[0][9:2]];
            void'(pend_due.pop_front());
            void'(pend_addr.pop_front());
        end else begin
            mrd_rvalid = 1'b0;
        end
        mrd_gnt   = (gnt_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        seg_ready = hold_ready ? 1'b0 : ((rdy_mode == 0) ? 1'b1 : ((cyc % 4) != 1));
        if (rst_n && mrd_req && mrd_gnt) begin
            pend_due.push_back(cyc + 2);
            pend_addr.push_back(mrd_addr);
            rd_count++;
        end
        if (rst_n && (done || pend_done))
            chk(done == pend_done, "R4", "done timing", 96'(done), 96'(pend_done));
        pend_done = 1'b0;
        if (rst_n && stall_q && seg_valid)
            chk({seg_flag, seg_addr, seg_len} == stall_seg, "R10", "stalled segment held",
                96'({seg_flag, seg_addr, seg_len}), 96'(stall_seg));
        stall_q   = seg_valid && !seg_ready;
        stall_seg = {seg_flag, seg_addr, seg_len};
        if (rst_n && seg_valid && seg_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected segment", 96'({seg_flag, seg_addr, seg_len}), 96'(0));
            end else begin
                logic [64:0] e;
                e = exp_q.pop_front();
                chk({seg_flag, seg_addr, seg_len} == e, "R3 R6", "segment",
                    96'({seg_flag, seg_addr, seg_len}), 96'(e));
                if (exp_q.size() == 0 && exp_done) pend_done = 1'b1;
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic put_desc(input int i, input logic [31:0] l, input logic [31:0] b, input logic [31:0] s);
        mem[(LIST >> 2) + 3*i]     = l;
        mem[(LIST >> 2) + 3*i + 1] = b;
        mem[(LIST >> 2) + 3*i + 2] = s;
    endtask

    // Preload registers with descriptor 0 of the list.
    task automatic load_first();
        r_list = LIST;
        r_link = mem[LIST >> 2];
        r_base = mem[(LIST >> 2) + 1];
        r_size = mem[(LIST >> 2) + 2];
        wr(3'd1, r_list); wr(3'd2, r_link); wr(3'd3, r_base); wr(3'd4, r_size);
    endtask

    // Behavioural walk of the chain from the programmed registers.
    task automatic build_expect(input bit chain);
        logic [31:0] l, b, s, a;
        exp_q.delete();
        exp_done = 1'b0; exp_err = 1'b0;
        l = r_link; b = r_base; s = r_size;
        for (int n = 0; n < 16; n++) begin
            if (b[1:0] != 0 || (chain && l[31] && (s % 32) != 0)) begin
                exp_err = 1'b1;
                return;
            end
            exp_q.push_back({l[29], b, s});
            if (!chain || !l[31]) begin
                exp_done = 1'b1;
                return;
            end
            a = r_list + {16'b0, l[15:0]};
            b = mem[a[9:2] + 1];
            if (l[30]) s = mem[a[9:2] + 2];
            l = mem[a[9:2]];
        end
    endtask

    task automatic run_and_check(input logic [31:0] ctrl, input string req, input int exp_reads);
        bit fin;
        fin = 1'b0;
        rd_count = 0;
        wr(3'd0, ctrl);
        for (int k = 0; k < 3000 && !fin; k++) begin
            @(negedge clk);
            if (done || err) fin = 1'b1;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, "all segments issued", 96'(exp_q.size()), 96'(0));
        chk(err == exp_err, req, "err outcome", 96'(err), 96'(exp_err));
        if (exp_reads >= 0)
            chk(rd_count == exp_reads, req, "descriptor reads", 96'(rd_count), 96'(exp_reads));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({seg_valid, mrd_req, done, err} == 4'b0, "R1", "reset outputs",
            96'({seg_valid, mrd_req, done, err}), 96'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 single mode; link claims a next descriptor and size is odd, both ignored
        put_desc(0, NXT | UPD | 32'd12, 32'h0000_0200, 32'd100);
        load_first();
        build_expect(1'b0);
        run_and_check(32'h1, "R2", 0);

        // R3 R6 four-deep chain, all sizes reloaded, back-pressure and slow grants
        rdy_mode = 1; gnt_mode = 1;
        put_desc(0, NXT | UPD | 32'd12,       32'h1000, 32'd64);
        put_desc(1, NXT | UPD | ACK | 32'd24, 32'h1100, 32'd128);
        put_desc(2, NXT | UPD | 32'd36,       32'h1204, 32'd32);
        put_desc(3, ACK,                      32'h1300, 32'd50);
        load_first();
        build_expect(1'b1);
        run_and_check(32'h3, "R3", 9);

        // R5 size kept when update flag clear; R8 unaligned final size allowed
        rdy_mode = 0; gnt_mode = 0;
        put_desc(0, NXT | 32'd12,       32'h2000, 32'd96);
        put_desc(1, NXT | UPD | 32'd24, 32'h2040, 32'd999);
        put_desc(2, ACK,                32'h2100, 32'd7);
        load_first();
        build_expect(1'b1);
        run_and_check(32'h3, "R5", 5);

        // R8 non-final unaligned size stops the chain with err
        rdy_mode = 1;
        put_desc(0, NXT | UPD | 32'd12, 32'h3000, 32'd64);
        put_desc(1, NXT | UPD | 32'd24, 32'h3100, 32'd40);
        put_desc(2, 32'h0,              32'h3200, 32'd64);
        load_first();
        build_expect(1'b1);
        run_and_check(32'h3, "R8", 3);

        // R7 unaligned base: no segment, err
        put_desc(0, 32'h0, 32'h0000_4002, 32'd64);
        load_first();
        build_expect(1'b0);
        run_and_check(32'h1, "R7", 0);

        // R7 unaligned base in a fetched descriptor
        put_desc(0, NXT | UPD | 32'd12, 32'h5000, 32'd32);
        put_desc(1, 32'h0,              32'h5101, 32'd32);
        load_first();
        build_expect(1'b1);
        run_and_check(32'h3, "R7", 3);

        // R12 chain bit without run bit starts nothing
        put_desc(0, NXT | UPD | 32'd12, 32'h6000, 32'd32);
        put_desc(1, 32'h0,              32'h6100, 32'd32);
        load_first();
        exp_q.delete(); exp_done = 1'b0;
        rd_count = 0;
        wr(3'd0, 32'h2);
        repeat (40) @(negedge clk);
        chk({seg_valid, mrd_req, done} == 3'b0 && rd_count == 0, "R12", "idle after chain-only write",
            96'({seg_valid, mrd_req, done, 8'(rd_count)}), 96'(0));

        // R9 zero control write stops a pending segment
        hold_ready = 1'b1;
        build_expect(1'b1);
        wr(3'd0, 32'h3);
        for (int k = 0; k < 50 && !seg_valid; k++) @(negedge clk);
        chk(seg_valid == 1'b1, "R9", "segment pending before stop", 96'(seg_valid), 96'(1));
        exp_q.delete(); exp_done = 1'b0;
        wr(3'd0, 32'h0);
        chk({seg_valid, mrd_req} == 2'b0, "R9", "stopped outputs", 96'({seg_valid, mrd_req}), 96'(0));
        hold_ready = 1'b0;
        repeat (30) @(negedge clk);
        chk({seg_valid, done, err} == 3'b0, "R9", "stays idle after stop",
            96'({seg_valid, done, err}), 96'(0));

        // R2 restart in single mode after stop reuses programmed registers
        load_first();
        build_expect(1'b0);
        run_and_check(32'h1, "R2", 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule